// File: doc/BRIEF.md
# Primary Slot Page Decoder

This block sits between a CPU address bus and the memory regions of a retro home-computer memory system. The address space is split into four equal pages, and an 8-bit slot-select register assigns one of four slots to each page independently, two bits per page. Each access is then split into an 8-way block index and an in-block offset. The access is steered to one of three targets: on-chip RAM in slot 3, a cartridge window in the slots flagged as cartridge slots, or an empty region that reads as all ones.

Software writes the slot-select register through a dedicated port and can read it back. Cartridge accesses go out on a request port that carries the slot, block index, offset and write data, and the cartridge's read byte comes back on `cart_rdata`. The bank logic behind that port lies outside this block. The address width is a parameter: 16 gives the full 64KB map with 8KB blocks, and the smaller default keeps the on-chip RAM small while keeping every ratio the same. The RAM size is given in blocks (8, 4, 2 or 1). Any other value stops elaboration.

Top module: `slot_page_decoder`

## Requirements
- R1: The slot for page n is `slot_q[2n+1:2n]`, so page 0 uses bits 1:0 and page 3 uses bits 7:6. Page n is the n-th quarter of the address space.
- R2: The top two address bits select the page. The top three address bits are the block index (0..7) reported on `cart_block`, and the remaining low bits are the offset reported on `cart_ofs`.
- R3: `slot_rdata` equals the value last written. A write with `slot_wr` high takes effect at the next rising clock edge. While `slot_wr` is low, the register holds.
- R4: During asynchronous reset (`rst_n` low) the slot register clears to 0, so every page selects slot 0, and every RAM byte clears to 0.
- R5: In slot 3, RAM occupies blocks 0..7 when RAM_BLOCKS=8, blocks 4..7 when it is 4, and blocks 6..7 when it is 2 or 1. The other blocks of slot 3 are empty.
- R6: The RAM byte index is the linear address (block × block size + offset) modulo the RAM size, so a RAM smaller than its window repeats across it.
- R7: A CPU write (`cpu_wr`) to a RAM block stores `cpu_wdata` at the next rising edge, and a later read returns it.
- R8: A read from an empty block returns 8'hFF. A write to an empty block changes no RAM byte and raises no cartridge strobe.
- R9: An access to a slot whose bit is set in CART_SLOTS (default slots 1 and 2) raises `cart_rd` or `cart_wr` together with the slot, block, offset and write data. A read in such a slot returns `cart_rdata` on `cpu_rdata`.
- R10: `cart_rd` and `cart_wr` stay low for every access that lands in a slot not flagged as a cartridge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read byte, combinational from address and slot register |
| slot_wr | input | 1 | Slot-select register write strobe |
| slot_wdata | input | 8 | Packed slot-select value to write |
| slot_rdata | output | 8 | Slot-select register readback |
| cart_rdata | input | 8 | Byte returned by the cartridge window |
| cart_rd | output | 1 | Cartridge read request |
| cart_wr | output | 1 | Cartridge write request |
| cart_slot | output | 2 | Slot of the cartridge request |
| cart_block | output | 3 | Block index of the cartridge request |
| cart_ofs | output | ADDR_W-3 | Offset within the block |
| cart_wdata | output | 8 | Write byte for the cartridge request |

## Verification
The hardest case to reach is mirroring together with RAM placement. A write through one block must appear at the same offset in a different block of a smaller RAM, while a write aimed at an unmapped block of that RAM must leave the aliased byte untouched. The bench drives three instances from the same stimulus, with 8, 4 and 1 RAM blocks. A single write sequence therefore lands as a stored byte in one instance, as a mirrored byte in another and as an ignored write in the third, and each instance is read back afterwards at the aliasing addresses.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;

    typedef enum logic [1:0] {
        TGT_EMPTY = 2'd0,
        TGT_RAM   = 2'd1,
        TGT_CART  = 2'd2
    } target_e;

    // First block of slot 3 occupied by RAM; -1 marks an unsupported size.
    function automatic int ram_first_block(input int nblk);
        case (nblk)
            8:       return 0;
            4:       return 4;
            2, 1:    return 6;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/spd_slot_reg.sv
`timescale 1ns/1ps
module spd_slot_reg #(
    parameter int PAGES = 4,
    parameter int SEL_W = 2,
    localparam int REG_W = PAGES * SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] slot_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else if (wr) slot_q <= wdata;
    end

    assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> slot_q == $past(wdata));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(slot_q));

endmodule

// File: rtl/spd_router.sv
`timescale 1ns/1ps
module spd_router
    import spd_pkg::*;
#(
    parameter int         ADDR_W     = 10,
    parameter int         RAM_BLOCKS = 8,
    parameter logic [3:0] CART_SLOTS = 4'b0110,
    localparam int PAGE_W = 2,
    localparam int BLK_W  = 3,
    localparam int OFS_W  = ADDR_W - BLK_W,
    localparam int FIRST  = ram_first_block(RAM_BLOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        slot_q,
    output logic [1:0]        slot,
    output logic [BLK_W-1:0]  block,
    output logic [OFS_W-1:0]  ofs,
    output target_e           target
);

    logic [PAGE_W-1:0] page;

    assign page  = addr[ADDR_W-1 -: PAGE_W];
    assign block = addr[ADDR_W-1 -: BLK_W];
    assign ofs   = addr[OFS_W-1:0];
    assign slot  = slot_q[page*2 +: 2];

    always_comb begin
        target = TGT_EMPTY;
        if (CART_SLOTS[slot])
            target = TGT_CART;
        else if (slot == 2'd3 && block >= BLK_W'(FIRST))
            target = TGT_RAM;
    end

endmodule

// File: rtl/spd_ram.sv
`timescale 1ns/1ps
module spd_ram #(
    parameter int ADDR_W     = 10,
    parameter int RAM_BLOCKS = 8,
    localparam int OFS_W     = ADDR_W - 3,
    localparam int IDX_W     = $clog2(RAM_BLOCKS) + OFS_W,
    localparam int RAM_BYTES = RAM_BLOCKS << OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] lin,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0]       mem [RAM_BYTES];
    logic [IDX_W-1:0] idx;

    // Dropping the high bits of the linear address gives the mirror.
    assign idx = lin[IDX_W-1:0];

    generate
        if (IDX_W < ADDR_W) begin : g_mirror
            logic unused_hi;
            assign unused_hi = ^lin[ADDR_W-1:IDX_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_BYTES; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

    assert_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(idx)] == $past(wdata));

endmodule

// File: rtl/slot_page_decoder.sv
`timescale 1ns/1ps
module slot_page_decoder
    import spd_pkg::*;
#(
    parameter int         ADDR_W     = 10,
    parameter int         RAM_BLOCKS = 8,
    parameter logic [3:0] CART_SLOTS = 4'b0110,
    localparam int OFS_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [7:0]        cpu_rdata,
    input  logic              slot_wr,
    input  logic [7:0]        slot_wdata,
    output logic [7:0]        slot_rdata,
    input  logic [7:0]        cart_rdata,
    output logic              cart_rd,
    output logic              cart_wr,
    output logic [1:0]        cart_slot,
    output logic [2:0]        cart_block,
    output logic [OFS_W-1:0]  cart_ofs,
    output logic [7:0]        cart_wdata
);

    // Elaboration-time rejection of unsupported geometry.
    initial begin
        assert (ram_first_block(RAM_BLOCKS) >= 0)
            else $fatal(1, "RAM_BLOCKS must be 8, 4, 2 or 1");
        assert (ADDR_W >= 4 && !CART_SLOTS[3])
            else $fatal(1, "ADDR_W too small or slot 3 flagged as cartridge");
    end

    logic [7:0]       slot_q;
    logic [1:0]       slot;
    logic [2:0]       block;
    logic [OFS_W-1:0] ofs;
    target_e          target;
    logic [7:0]       ram_rdata;

    spd_slot_reg #(.PAGES(4), .SEL_W(2)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (slot_wr),
        .wdata  (slot_wdata),
        .slot_q (slot_q)
    );

    spd_router #(
        .ADDR_W     (ADDR_W),
        .RAM_BLOCKS (RAM_BLOCKS),
        .CART_SLOTS (CART_SLOTS)
    ) u_route (
        .addr   (cpu_addr),
        .slot_q (slot_q),
        .slot   (slot),
        .block  (block),
        .ofs    (ofs),
        .target (target)
    );

    spd_ram #(.ADDR_W(ADDR_W), .RAM_BLOCKS(RAM_BLOCKS)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cpu_wr && target == TGT_RAM),
        .lin   ({block, ofs}),
        .wdata (cpu_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        unique case (target)
            TGT_RAM:  cpu_rdata = ram_rdata;
            TGT_CART: cpu_rdata = cart_rdata;
            default:  cpu_rdata = 8'hFF;
        endcase
    end

    assign slot_rdata = slot_q;
    assign cart_rd    = cpu_rd && target == TGT_CART;
    assign cart_wr    = cpu_wr && target == TGT_CART;
    assign cart_slot  = slot;
    assign cart_block = block;
    assign cart_ofs   = ofs;
    assign cart_wdata = cpu_wdata;

    assert_empty_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        target == TGT_EMPTY |-> cpu_rdata == 8'hFF);

    assert_cart_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_rd || cart_wr) |-> CART_SLOTS[cart_slot]);

endmodule

// File: tb/tb_slot_page_decoder.sv
`timescale 1ns/1ps
module tb_slot_page_decoder;

    localparam int AW = 10;
    localparam int OW = AW - 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic          slot_wr = 1'b0;
    logic [7:0]    slot_wdata = '0;
    logic [7:0]    cart_rdata = 8'hA5;

    logic [7:0]    rd8, sr8, rd4, sr4, rd1, sr1;
    logic          crd8, cwr8, crd4, cwr4, crd1, cwr1;
    logic [1:0]    cs8, cs4, cs1;
    logic [2:0]    cb8, cb4, cb1;
    logic [OW-1:0] co8, co4, co1;
    logic [7:0]    cw8, cw4, cw1;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;   // 100 MHz

    slot_page_decoder #(.ADDR_W(AW), .RAM_BLOCKS(8)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(rd8), .slot_wr(slot_wr),
        .slot_wdata(slot_wdata), .slot_rdata(sr8), .cart_rdata(cart_rdata),
        .cart_rd(crd8), .cart_wr(cwr8), .cart_slot(cs8), .cart_block(cb8),
        .cart_ofs(co8), .cart_wdata(cw8));

    slot_page_decoder #(.ADDR_W(AW), .RAM_BLOCKS(4)) dut_r4 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(rd4), .slot_wr(slot_wr),
        .slot_wdata(slot_wdata), .slot_rdata(sr4), .cart_rdata(cart_rdata),
        .cart_rd(crd4), .cart_wr(cwr4), .cart_slot(cs4), .cart_block(cb4),
        .cart_ofs(co4), .cart_wdata(cw4));

    slot_page_decoder #(.ADDR_W(AW), .RAM_BLOCKS(1)) dut_r1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(rd1), .slot_wr(slot_wr),
        .slot_wdata(slot_wdata), .slot_rdata(sr1), .cart_rdata(cart_rdata),
        .cart_rd(crd1), .cart_wr(cwr1), .cart_slot(cs1), .cart_block(cb1),
        .cart_ofs(co1), .cart_wdata(cw1));

    // kind: 0 empty, 1 cartridge, 2 RAM (reads 0 right after reset)
    typedef struct packed {
        logic [7:0]    sel;
        logic [AW-1:0] addr;
        logic [1:0]    kind;
        logic [1:0]    slot;
        logic [2:0]    blk;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{8'hE4, 10'h010, 2'd0, 2'd0, 3'd0},
        '{8'hE4, 10'h150, 2'd1, 2'd1, 3'd2},
        '{8'hE4, 10'h2A0, 2'd1, 2'd2, 3'd5},
        '{8'hE4, 10'h3F0, 2'd2, 2'd3, 3'd7},
        '{8'h1B, 10'h005, 2'd2, 2'd3, 3'd0},
        '{8'h1B, 10'h180, 2'd1, 2'd2, 3'd3},
        '{8'h1B, 10'h200, 2'd1, 2'd1, 3'd4},
        '{8'h1B, 10'h37F, 2'd0, 2'd0, 3'd6},
        '{8'hFF, 10'h0C0, 2'd2, 2'd3, 3'd1},
        '{8'h55, 10'h399, 2'd1, 2'd1, 3'd7},
        '{8'hAA, 10'h000, 2'd1, 2'd2, 3'd0},
        '{8'h00, 10'h2FF, 2'd0, 2'd0, 3'd5}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_sel(input logic [7:0] v);
        @(negedge clk);
        slot_wr = 1'b1;
        slot_wdata = v;
        @(negedge clk);
        slot_wr = 1'b0;
    endtask

    task automatic rd_at(input logic [AW-1:0] a);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_addr = a;
        cpu_rd = 1'b1;
        #1;
    endtask

    task automatic wr_begin(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_addr = a;
        cpu_wdata = d;
        cpu_wr = 1'b1;
        #1;
    endtask

    task automatic wr_end();
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // R4: reset state
        chk("R4 slot register cleared", sr8, 8'h00);
        rd_at(10'h1A5);
        chk("R4 all pages slot 0 reads empty", rd8, 8'hFF);
        chk("R10 no cart read in slot 0", crd8, 0);

        // Table walk: R1 R2 R3 R9 R10
        foreach (VECS[i]) begin
            set_sel(VECS[i].sel);
            chk("R3 readback", sr8, VECS[i].sel);
            rd_at(VECS[i].addr);
            chk("R9 R10 cart read strobe", crd8, (VECS[i].kind == 2'd1) ? 1 : 0);
            case (VECS[i].kind)
                2'd0: chk("R1 R8 empty page read", rd8, 8'hFF);
                2'd1: chk("R1 R9 cart data passthrough", rd8, 8'hA5);
                default: chk("R1 R4 RAM page read after reset", rd8, 8'h00);
            endcase
            if (VECS[i].kind == 2'd1) begin
                chk("R1 cart slot", cs8, VECS[i].slot);
                chk("R2 cart block", cb8, VECS[i].blk);
                chk("R2 cart offset", co8, VECS[i].addr[OW-1:0]);
            end
        end

        // R7: RAM store and readback
        set_sel(8'hFF);
        wr_begin(10'h1A5, 8'h3C);
        chk("R10 no cart write to RAM", cwr8, 0);
        wr_end();
        wr_begin(10'h005, 8'h77); wr_end();
        rd_at(10'h1A5); chk("R7 RAM readback 1A5", rd8, 8'h3C);
        rd_at(10'h005); chk("R7 RAM readback 005", rd8, 8'h77);

        // R4: reset clears RAM and register
        do_reset();
        chk("R4 register cleared again", sr8, 8'h00);
        set_sel(8'hFF);
        rd_at(10'h1A5); chk("R4 RAM cleared by reset", rd8, 8'h00);

        // R8: empty write ignored
        set_sel(8'h00);
        wr_begin(10'h1A5, 8'h12);
        chk("R8 R10 no cart write to empty", cwr8, 0);
        wr_end();
        set_sel(8'hFF);
        rd_at(10'h1A5); chk("R8 RAM untouched by empty write", rd8, 8'h00);

        // R9: cartridge write request
        set_sel(8'h55);
        wr_begin(10'h2C3, 8'h9E);
        chk("R9 cart write strobe", cwr8, 1);
        chk("R9 no cart read during write", crd8, 0);
        chk("R9 cart write slot", cs8, 1);
        chk("R9 cart write block", cb8, 5);
        chk("R9 cart write offset", co8, 7'h43);
        chk("R9 cart write data", cw8, 8'h9E);
        wr_end();
        cart_rdata = 8'h3D;
        rd_at(10'h2C3); chk("R9 cart read data", rd8, 8'h3D);

        // R3: hold without strobe
        @(negedge clk); slot_wdata = 8'h0F;
        @(negedge clk); @(negedge clk);
        chk("R3 hold without strobe", sr8, 8'h55);

        // R5 R6: placement and mirroring across three RAM sizes
        set_sel(8'hFF);
        wr_begin(10'h3C5, 8'h5A); wr_end();
        rd_at(10'h345);
        chk("R6 1-block RAM mirrors block 7 into block 6", rd1, 8'h5A);
        chk("R6 4-block RAM no alias at block 6", rd4, 8'h00);
        chk("R6 8-block RAM no alias at block 6", rd8, 8'h00);
        rd_at(10'h3C5); chk("R6 4-block RAM stores block 7", rd4, 8'h5A);
        wr_begin(10'h245, 8'h66); wr_end();
        rd_at(10'h245);
        chk("R5 4-block RAM maps block 4", rd4, 8'h66);
        chk("R5 1-block RAM leaves block 4 empty", rd1, 8'hFF);
        chk("R5 8-block RAM maps block 4", rd8, 8'h66);
        rd_at(10'h345); chk("R5 R8 ignored write left alias intact", rd1, 8'h5A);
        rd_at(10'h045);
        chk("R5 4-block RAM leaves block 0 empty", rd4, 8'hFF);
        chk("R5 8-block RAM maps block 0", rd8, 8'h00);
        wr_begin(10'h145, 8'h99); wr_end();
        rd_at(10'h345); chk("R8 write to empty block 2 not aliased", rd4, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule